// File: doc/BRIEF.md
# Parallel NOR Flash Bus Front End

This block is the clocked bus side of an emulated byte-wide parallel NOR flash. Its inputs are the asynchronous active-low strobes (chip select, output enable, write strobe, hardware reset), an 18-bit address, an 8-bit write bus, a flag that marks the identification high voltage on address bit 9, and a supply-lockout flag. The block brings all of these into the system clock domain. It filters short strobe glitches and sorts each bus cycle into read, write, output-disable or standby.

A completed write cycle produces a one-clock command strobe toward a downstream command sequencer. The strobe carries the address taken when the write cycle began and the data present when it ended. A read cycle drives either the array byte or an identification code onto an output bus, together with an output enable. The block also reports automatic standby after the bus has been idle for a set time, and it runs the hardware reset hold and recovery sequence. It decodes the block index and block size of the last command address for a top-boot or bottom-boot layout.

Top module: `nor_bus_front`

## Requirements
- R1: After system reset, `ready` is 1, `cmd_valid` is 0 and `dq_oe` is 0 while output enable is high.
- R2: While chip select is high, `standby` is 1, `dq_oe` is 0, and a write-strobe pulse issues no command.
- R3: With chip select and output enable low and the write strobe high, `dq_oe` is 1, `arr_addr` follows the address input and `dq_out` equals `arr_data`.
- R4: A write cycle (chip select and write strobe both low) gives exactly one `cmd_valid` pulse of one clock. `cmd_addr` is the address present when the second of the two strobes fell. `cmd_data` is the data present when the first of them rose.
- R5: A write cycle during which output enable is low at any time issues no command.
- R6: A low pulse on chip select or on the write strobe that is shorter than `FILT_CYC` clocks is ignored.
- R7: `auto_standby` rises after `IDLE_CYC` clocks with no change on the bus inputs. A read in progress keeps driving. Any bus change clears `auto_standby`.
- R8: With `a9_hv` = 1 and address bit 1 = 0, a read returns 20h when address bit 0 = 0. When address bit 0 = 1 it returns B0h (top boot) or 34h (bottom boot). With address bit 1 = 1 the array byte is returned.
- R9: `blk_idx`/`blk_kb` decode `cmd_addr`. For top boot, blocks 0–2 are 64 KB at 00000h–2FFFFh and block 3 is 32 KB at 30000h–37FFFh. Blocks 4 and 5 are 8 KB at 38000h and 3A000h, and block 6 is 16 KB at 3C000h. Bottom boot mirrors this layout, with the 16 KB block 0 at 00000h.
- R10: Reset held low for at least `RST_MIN` clocks drops `ready`. While not ready, there is no drive and no command. `ready` returns `REC_CYC` clocks after reset is released. A shorter reset pulse leaves `ready` at 1.
- R11: A write that ends while `vlow` is 1 issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| rp_n | input | 1 | Hardware reset pin, active low, asynchronous |
| addr | input | 18 | Bus address |
| dq_in | input | 8 | Bus write data |
| a9_hv | input | 1 | Identification high voltage present on address bit 9 |
| vlow | input | 1 | Supply below lockout level |
| arr_data | input | 8 | Byte read from the array |
| arr_addr | output | 18 | Synchronised read address to the array |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Read data drive enable |
| cmd_valid | output | 1 | One-clock command strobe |
| cmd_addr | output | 18 | Command address |
| cmd_data | output | 8 | Command data |
| blk_idx | output | 3 | Block index of `cmd_addr` |
| blk_kb | output | 7 | Block size of `cmd_addr` in KB |
| standby | output | 1 | Chip select inactive |
| auto_standby | output | 1 | Bus idle time reached |
| ready | output | 1 | Not in hardware reset or recovery |

## Verification
Two functions can meet in one cycle: the idle counter expiring and a read that is still being driven. A long unchanged read is held until `auto_standby` rises, and the bench checks that `dq_oe` and `dq_out` keep their read values at that point. A second case sets a write cycle against hardware reset. The write strobe is lowered while reset is held and the bench judges that no command strobe appears, both during the reset and after recovery ends.

// File: rtl/nor_bus_pkg.sv
package nor_bus_pkg;
   localparam logic [7:0] MFR_CODE = 8'h20;
   localparam logic [7:0] DEV_CODE_TOP = 8'hB0;
   localparam logic [7:0] DEV_CODE_BOT = 8'h34;

   typedef struct packed {
      logic [2:0] idx;
      logic [6:0] kb;
   } blk_info_t;
endpackage

// File: rtl/nor_sync.sv
module nor_sync #(
   parameter int W = 1,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= INIT;
         q    <= INIT;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/nor_glitch_filter.sv
module nor_glitch_filter #(
   parameter int CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (CYC < 0) begin : g_bad
         $error("nor_glitch_filter: CYC must not be negative");
      end
      if (CYC == 0) begin : g_pass
         assign dout = din;
      end else begin : g_filt
         localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);
         logic [CW-1:0] cnt;
         logic          held;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               held <= 1'b1;
               cnt  <= '0;
            end else if (din == held) begin
               cnt <= '0;
            end else if (cnt == CW'(CYC - 1)) begin
               held <= din;
               cnt  <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign dout = held;
      end
   endgenerate
endmodule

// File: rtl/nor_reset_track.sv
module nor_reset_track #(
   parameter int RST_MIN = 8,
   parameter int REC_CYC = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rp_s,
   output logic in_rst
);
   localparam int LW = $clog2(RST_MIN + 1);
   localparam int RW = $clog2(REC_CYC + 1);

   logic [LW-1:0] lo_cnt;
   logic [RW-1:0] rec_cnt;

   generate
      if (RST_MIN < 1) begin : g_bad_min
         $error("nor_reset_track: RST_MIN must be at least 1");
      end
      if (REC_CYC < 1) begin : g_bad_rec
         $error("nor_reset_track: REC_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt  <= '0;
         rec_cnt <= '0;
         in_rst  <= 1'b0;
      end else if (!rp_s) begin
         rec_cnt <= '0;
         if (lo_cnt != LW'(RST_MIN)) lo_cnt <= lo_cnt + 1'b1;
         if (lo_cnt == LW'(RST_MIN - 1)) in_rst <= 1'b1;
      end else begin
         lo_cnt <= '0;
         if (in_rst) begin
            if (rec_cnt == RW'(REC_CYC - 1)) begin
               in_rst  <= 1'b0;
               rec_cnt <= '0;
            end else begin
               rec_cnt <= rec_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/nor_block_map.sv
module nor_block_map
   import nor_bus_pkg::*;
#(
   parameter bit BOOT_TOP = 1'b1
) (
   input  logic [17:0] a,
   output blk_info_t   info
);
   generate
      if (BOOT_TOP) begin : g_top
         always_comb begin
            if (a[17:16] != 2'b11) begin
               info = '{idx: {1'b0, a[17:16]}, kb: 7'd64};
            end else if (!a[15]) begin
               info = '{idx: 3'd3, kb: 7'd32};
            end else if (a[14]) begin
               info = '{idx: 3'd6, kb: 7'd16};
            end else begin
               info = '{idx: a[13] ? 3'd5 : 3'd4, kb: 7'd8};
            end
         end
      end else begin : g_bot
         always_comb begin
            if (a[17:16] != 2'b00) begin
               info = '{idx: 3'd3 + {1'b0, a[17:16]}, kb: 7'd64};
            end else if (a[15]) begin
               info = '{idx: 3'd3, kb: 7'd32};
            end else if (!a[14]) begin
               info = '{idx: 3'd0, kb: 7'd16};
            end else begin
               info = '{idx: a[13] ? 3'd2 : 3'd1, kb: 7'd8};
            end
         end
      end
   endgenerate
endmodule

// File: rtl/nor_bus_front.sv
module nor_bus_front
   import nor_bus_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int DATA_W   = 8,
   parameter int FILT_CYC = 3,
   parameter int IDLE_CYC = 19,
   parameter int RST_MIN  = 8,
   parameter int REC_CYC  = 12,
   parameter bit BOOT_TOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              rp_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   input  logic              a9_hv,
   input  logic              vlow,
   input  logic [DATA_W-1:0] arr_data,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic              cmd_valid,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data,
   output logic [2:0]        blk_idx,
   output logic [6:0]        blk_kb,
   output logic              standby,
   output logic              auto_standby,
   output logic              ready
);
   localparam int BUS_W = ADDR_W + DATA_W;
   localparam int ACT_W = BUS_W + 3;
   localparam int IW    = $clog2(IDLE_CYC + 1);
   localparam logic [DATA_W-1:0] DEV_CODE = BOOT_TOP ? DEV_CODE_TOP : DEV_CODE_BOT;

   generate
      if (ADDR_W != 18) begin : g_bad_aw
         $error("nor_bus_front: block map needs ADDR_W of 18");
      end
      if (DATA_W != 8) begin : g_bad_dw
         $error("nor_bus_front: identification codes need DATA_W of 8");
      end
      if (IDLE_CYC < 1) begin : g_bad_idle
         $error("nor_bus_front: IDLE_CYC must be at least 1");
      end
   endgenerate

   // synchronisers
   logic [5:0] ctl_s;
   logic [BUS_W-1:0] bus_s;
   logic ce_s, oe_s, we_s, rp_s, a9_s, lock_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] dq_s;

   nor_sync #(.W(6), .INIT(6'b111100)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ce_n, oe_n, we_n, rp_n, a9_hv, vlow}), .q(ctl_s));

   nor_sync #(.W(BUS_W), .INIT('0)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d({addr, dq_in}), .q(bus_s));

   assign {ce_s, oe_s, we_s, rp_s, a9_s, lock_s} = ctl_s;
   assign {addr_s, dq_s} = bus_s;

   // strobe filters
   logic ce_f, we_f;

   nor_glitch_filter #(.CYC(FILT_CYC)) u_ce_filt (
      .clk(clk), .rst_n(rst_n), .din(ce_s), .dout(ce_f));

   nor_glitch_filter #(.CYC(FILT_CYC)) u_we_filt (
      .clk(clk), .rst_n(rst_n), .din(we_s), .dout(we_f));

   // hardware reset sequencing
   logic in_rst;

   nor_reset_track #(.RST_MIN(RST_MIN), .REC_CYC(REC_CYC)) u_rst (
      .clk(clk), .rst_n(rst_n), .rp_s(rp_s), .in_rst(in_rst));

   assign ready = !in_rst;

   // read path
   logic rd_act, id_sel;

   assign rd_act   = !ce_f && !oe_s && we_f && !in_rst;
   assign id_sel   = a9_s && !addr_s[1];
   assign arr_addr = addr_s;
   assign dq_oe    = rd_act;
   assign dq_out   = id_sel ? (addr_s[0] ? DEV_CODE : MFR_CODE) : arr_data;
   assign standby  = ce_f;

   // write path
   logic wr_act, wr_act_d, wr_start, wr_end, wr_bad;
   logic [ADDR_W-1:0] wr_addr;

   assign wr_act   = !ce_f && !we_f;
   assign wr_start = wr_act && !wr_act_d;
   assign wr_end   = !wr_act && wr_act_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_act_d  <= 1'b0;
         wr_bad    <= 1'b0;
         wr_addr   <= '0;
         cmd_valid <= 1'b0;
         cmd_addr  <= '0;
         cmd_data  <= '0;
      end else begin
         wr_act_d  <= wr_act;
         cmd_valid <= 1'b0;
         if (wr_start) begin
            wr_addr <= addr_s;
            wr_bad  <= !oe_s || in_rst;
         end else if (wr_act && (!oe_s || in_rst)) begin
            wr_bad <= 1'b1;
         end
         if (wr_end && !wr_bad && !lock_s && !in_rst) begin
            cmd_valid <= 1'b1;
            cmd_addr  <= wr_addr;
            cmd_data  <= dq_s;
         end
      end
   end

   // block decode of the command address
   blk_info_t blk;

   nor_block_map #(.BOOT_TOP(BOOT_TOP)) u_map (.a(cmd_addr), .info(blk));

   assign blk_idx = blk.idx;
   assign blk_kb  = blk.kb;

   // automatic standby
   logic [ACT_W-1:0] act_vec, act_prev;
   logic [IW-1:0]    idle_cnt;

   assign act_vec = {ce_f, oe_s, we_f, bus_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_prev <= {3'b111, {BUS_W{1'b0}}};
         idle_cnt <= '0;
      end else begin
         act_prev <= act_vec;
         if (act_vec != act_prev) idle_cnt <= '0;
         else if (idle_cnt != IW'(IDLE_CYC)) idle_cnt <= idle_cnt + 1'b1;
      end
   end

   assign auto_standby = (idle_cnt == IW'(IDLE_CYC));
endmodule

// File: rtl/nor_bus_front_chk.sv
module nor_bus_front_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic       dq_oe,
   input logic       standby,
   input logic       ready,
   input logic       lock_s,
   input logic [6:0] blk_kb
);
   assert_strobe_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> !dq_oe);

   assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (!dq_oe && !cmd_valid));

   assert_lockout_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !$past(lock_s));

   assert_blk_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(blk_kb) == 1);
endmodule

bind nor_bus_front nor_bus_front_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .dq_oe(dq_oe),
   .standby(standby), .ready(ready), .lock_s(lock_s), .blk_kb(blk_kb));

// File: tb/nor_bus_front_test.sv
module nor_bus_front_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1;
   logic [17:0] addr = '0;
   logic [7:0]  dq_in = '0;
   logic a9_hv = 1'b0, vlow = 1'b0;
   logic [7:0]  arr_data;
   logic [17:0] arr_addr, cmd_addr;
   logic [7:0]  dq_out, cmd_data;
   logic dq_oe, cmd_valid, standby, auto_standby, ready;
   logic [2:0] blk_idx;
   logic [6:0] blk_kb;

   int errors = 0, checks = 0, n_cmd = 0;

   always #4 clk = ~clk;

   assign arr_data = arr_addr[7:0] ^ 8'h5A;

   nor_bus_front uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .rp_n(rp_n), .addr(addr), .dq_in(dq_in), .a9_hv(a9_hv), .vlow(vlow),
      .arr_data(arr_data), .arr_addr(arr_addr), .dq_out(dq_out), .dq_oe(dq_oe),
      .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .blk_idx(blk_idx), .blk_kb(blk_kb), .standby(standby),
      .auto_standby(auto_standby), .ready(ready));

   always @(posedge clk) if (cmd_valid) n_cmd <= n_cmd + 1;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic bus_write(logic [17:0] a, logic [7:0] d, bit oe_low);
      @(negedge clk);
      addr = a; dq_in = ~d; ce_n = 1'b0;
      wait_cyc(4);
      we_n = 1'b0;
      if (oe_low) oe_n = 1'b0;
      wait_cyc(8);
      addr = ~a; dq_in = d; oe_n = 1'b1;
      wait_cyc(8);
      we_n = 1'b1;
      wait_cyc(10);
      ce_n = 1'b1;
      wait_cyc(10);
   endtask

   task automatic t_reset_state();
      chk("R1 ready", ready, 1);
      chk("R1 cmd_valid", cmd_valid, 0);
      chk("R1 dq_oe", dq_oe, 0);
      chk("R1 cmd count", n_cmd, 0);
   endtask

   task automatic t_write();
      int n0 = n_cmd;
      bus_write(18'h12345, 8'hA7, 1'b0);
      chk("R4 one strobe", n_cmd - n0, 1);
      chk("R4 addr at start", cmd_addr, 18'h12345);
      chk("R4 data at end", cmd_data, 8'hA7);
      bus_write(18'h00F0F, 8'h3C, 1'b0);
      chk("R4 second strobe", n_cmd - n0, 2);
      chk("R4 second addr", cmd_addr, 18'h00F0F);
      chk("R4 second data", cmd_data, 8'h3C);
   endtask

   task automatic t_oe_write();
      int n0 = n_cmd;
      bus_write(18'h00111, 8'h11, 1'b1);
      chk("R5 oe low discards", n_cmd - n0, 0);
   endtask

   task automatic t_lockout();
      int n0 = n_cmd;
      vlow = 1'b1;
      bus_write(18'h00222, 8'h22, 1'b0);
      vlow = 1'b0;
      wait_cyc(4);
      chk("R11 lockout discards", n_cmd - n0, 0);
   endtask

   task automatic t_blocks();
      logic [17:0] al[6] = '{18'h3C000, 18'h3A000, 18'h38000, 18'h30000, 18'h2FFFF, 18'h00000};
      int ei[6] = '{6, 5, 4, 3, 2, 0};
      int ek[6] = '{16, 8, 8, 32, 64, 64};
      for (int i = 0; i < 6; i++) begin
         bus_write(al[i], 8'h00, 1'b0);
         chk("R9 block index", blk_idx, ei[i]);
         chk("R9 block size", blk_kb, ek[i]);
      end
   endtask

   task automatic t_read();
      logic [17:0] al[3] = '{18'h00000, 18'h2A5C3, 18'h3FFFF};
      ce_n = 1'b0; oe_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
         addr = al[i];
         wait_cyc(8);
         chk("R3 drive", dq_oe, 1);
         chk("R3 array addr", arr_addr, al[i]);
         chk("R3 data", dq_out, al[i][7:0] ^ 8'h5A);
      end
      oe_n = 1'b1;
      wait_cyc(4);
      chk("R3 oe high floats", dq_oe, 0);
      ce_n = 1'b1;
      wait_cyc(8);
   endtask

   task automatic t_id();
      ce_n = 1'b0; oe_n = 1'b0; a9_hv = 1'b1;
      addr = 18'h00000; wait_cyc(8);
      chk("R8 manufacturer code", dq_out, 8'h20);
      addr = 18'h00001; wait_cyc(8);
      chk("R8 device code", dq_out, 8'hB0);
      addr = 18'h00002; wait_cyc(8);
      chk("R8 A1 high gives array", dq_out, 8'h02 ^ 8'h5A);
      a9_hv = 1'b0; addr = 18'h00000; wait_cyc(8);
      chk("R8 no flag gives array", dq_out, 8'h5A);
      oe_n = 1'b1; ce_n = 1'b1; wait_cyc(8);
   endtask

   task automatic t_standby();
      int n0 = n_cmd;
      oe_n = 1'b0;
      wait_cyc(8);
      chk("R2 standby flag", standby, 1);
      chk("R2 no drive", dq_oe, 0);
      oe_n = 1'b1;
      we_n = 1'b0; wait_cyc(10); we_n = 1'b1; wait_cyc(10);
      chk("R2 write ignored", n_cmd - n0, 0);
   endtask

   task automatic t_glitch();
      int n0 = n_cmd;
      ce_n = 1'b0; wait_cyc(8);
      we_n = 1'b0; wait_cyc(2); we_n = 1'b1; wait_cyc(12);
      ce_n = 1'b1; wait_cyc(8);
      chk("R6 short write strobe", n_cmd - n0, 0);
      we_n = 1'b0; wait_cyc(8);
      ce_n = 1'b0; wait_cyc(2); ce_n = 1'b1; wait_cyc(12);
      we_n = 1'b1; wait_cyc(8);
      chk("R6 short chip select", n_cmd - n0, 0);
      chk("R6 standby held", standby, 1);
   endtask

   task automatic t_auto_standby();
      ce_n = 1'b0; oe_n = 1'b0; addr = 18'h01234;
      wait_cyc(40);
      chk("R7 auto standby", auto_standby, 1);
      chk("R7 still drives", dq_oe, 1);
      chk("R7 data kept", dq_out, 8'h34 ^ 8'h5A);
      addr = 18'h01235;
      wait_cyc(5);
      chk("R7 cleared by activity", auto_standby, 0);
      oe_n = 1'b1; ce_n = 1'b1; wait_cyc(8);
   endtask

   task automatic t_hw_reset();
      int n0 = n_cmd;
      rp_n = 1'b0; wait_cyc(4); rp_n = 1'b1; wait_cyc(6);
      chk("R10 short pulse ignored", ready, 1);
      rp_n = 1'b0; wait_cyc(20);
      chk("R10 in reset", ready, 0);
      ce_n = 1'b0; oe_n = 1'b0; wait_cyc(8);
      chk("R10 no drive in reset", dq_oe, 0);
      oe_n = 1'b1; wait_cyc(4);
      we_n = 1'b0; wait_cyc(8); we_n = 1'b1; wait_cyc(8);
      ce_n = 1'b1;
      rp_n = 1'b1; wait_cyc(6);
      chk("R10 recovering", ready, 0);
      wait_cyc(14);
      chk("R10 ready again", ready, 1);
      chk("R10 write in reset dropped", n_cmd - n0, 0);
   endtask

   initial begin
      fork
         begin
            wait_cyc(3);
            rst_n = 1'b1;
            wait_cyc(6);
            t_reset_state();
            t_write();
            t_oe_write();
            t_lockout();
            t_blocks();
            t_read();
            t_id();
            t_standby();
            t_glitch();
            t_auto_standby();
            t_hw_reset();
         end
         begin
            wait_cyc(100000);
            errors++;
            checks++;
            $display("FAIL watchdog actual=expired expected=done");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule